// File: doc/BRIEF.md
# Two-Port Mailbox Interrupt Flags

This block produces the message-passing interrupts of a memory with two independently clocked ports, called A and B. The two highest addresses of the address space are reserved as mailboxes. A write by port A to the all-ones address raises an active-low interrupt toward port B. Port B clears it by reading that same address. In the other direction, a write by port B to the all-ones-minus-one address raises an interrupt toward port A, and port A clears it by reading that address. The block only watches each port's address, select and write strobe. The memory array and the data paths sit elsewhere.

Each interrupt flag is held in the clock domain of the port that receives it. A mailbox write flips a toggle in the writer's domain. A two-flop synchronizer followed by an edge detector turns that flip into a one-cycle set pulse in the reader's domain. Each flag is a two-state machine. `MB_QUIET` (interrupt output high) moves to `MB_RAISED` when a set pulse arrives. `MB_RAISED` returns to `MB_QUIET` on a clearing read, unless a set pulse comes in the same cycle. The master reset forces both machines to `MB_QUIET` at once, with no clock needed. Its release is synchronized separately into each domain.

Top module: `mbx_irq_top`

## Requirements
- R1: While `sys_rst_n` is low, both `a_irq_n` and `b_irq_n` are high. This holds as soon as reset is asserted, without any clock edge. They stay high after release until a mailbox write arrives.
- R2: A port-A access with `a_cs_n`=0, `a_cs`=1 and `a_wr`=1 (write) to the all-ones address drives `b_irq_n` low just after the third rising `b_clk` edge that follows the `a_clk` edge sampling the write. `b_irq_n` is still high after the second such edge.
- R3: A port-B read (`b_wr`=0, with `b_cs_n`=0 and `b_cs`=1) of the all-ones address drives `b_irq_n` high just after the `b_clk` edge that samples it.
- R4: A port-B write with both selects active to the all-ones-minus-one address drives `a_irq_n` low just after the third rising `a_clk` edge that follows the sampling `b_clk` edge. `a_irq_n` is still high after the second such edge.
- R5: A port-A read with both selects active of the all-ones-minus-one address drives `a_irq_n` high just after the `a_clk` edge that samples it.
- R6: An access counts only if `cs_n`=0 and `cs`=1 in the same cycle. With either select inactive, no flag is set or cleared.
- R7: All other accesses leave both flags unchanged. This covers every non-mailbox address, a port reading the mailbox it writes, and a port writing the mailbox it reads.
- R8: When a set pulse and a clearing read meet on the same reader edge, the flag ends up raised. Suppose a clearing read is sampled on the k-th reader edge after the writer's sampling edge. The interrupt then remains asserted for k ≤ 3 and is released for k ≥ 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_rst_n | input | 1 | Asynchronous master reset, active low, for both ports |
| a_clk | input | 1 | Port A clock |
| a_addr | input | ADDR_W | Port A address |
| a_cs_n | input | 1 | Port A select, active low |
| a_cs | input | 1 | Port A select, active high |
| a_wr | input | 1 | Port A direction: 1 write, 0 read |
| b_clk | input | 1 | Port B clock |
| b_addr | input | ADDR_W | Port B address |
| b_cs_n | input | 1 | Port B select, active low |
| b_cs | input | 1 | Port B select, active high |
| b_wr | input | 1 | Port B direction: 1 write, 0 read |
| a_irq_n | output | 1 | Interrupt toward port A, active low |
| b_irq_n | output | 1 | Interrupt toward port B, active low |

## Verification
The bench uses a 4-bit address and sweeps every address, both directions and all four select combinations on each port. It runs the sweep once from a quiet state and once with both flags already raised. This separates a missing set from a missing clear, a swapped mailbox from a swapped port, and a single-select decode from the two-select rule. The sampling edge of a clearing read is then moved from the first to the sixth reader edge after a mailbox write, in both directions. That sweep pins the synchronizer latency and shows that a coinciding set beats the clear. Direct checks cover the exact edge on which each interrupt falls, and reset being applied while both flags are raised.

// File: rtl/mbx_pkg.sv
`timescale 1ns/10ps
package mbx_pkg;

    typedef enum logic {
        MB_QUIET  = 1'b0,
        MB_RAISED = 1'b1
    } mb_state_e;

    // An access is live only with both selects active together.
    function automatic logic port_live(input logic cs_n, input logic cs);
        return (!cs_n) && cs;
    endfunction

endpackage

// File: rtl/mbx_rst_sync.sv
`timescale 1ns/10ps
module mbx_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rst_n
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] shreg;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) shreg <= '0;
        else         shreg <= {shreg[LAST-1:0], 1'b1};
    end

    assign rst_n = shreg[LAST];

    // R1: the local reset only releases after the master reset has been high
    a_r1_release_after_master: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(rst_n) |-> $past(arst_n));

endmodule

// File: rtl/mbx_post_side.sv
`timescale 1ns/10ps
module mbx_post_side
    import mbx_pkg::*;
#(
    parameter int                ADDR_W = 18,
    parameter logic [ADDR_W-1:0] MBOX   = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cs_n,
    input  logic              cs,
    input  logic              wr,
    output logic              tgl
);
    logic post_hit;

    always_comb post_hit = port_live(cs_n, cs) && wr && (addr == MBOX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        tgl <= 1'b0;
        else if (post_hit) tgl <= ~tgl;
    end

endmodule

// File: rtl/mbx_sync_edge.sv
`timescale 1ns/10ps
module mbx_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tgl_in,
    output logic set_pulse
);
    localparam int TOP = STAGES;

    logic [TOP:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[TOP-1:0], tgl_in};
    end

    assign set_pulse = chain[TOP-1] ^ chain[TOP];

endmodule

// File: rtl/mbx_flag_fsm.sv
`timescale 1ns/10ps
module mbx_flag_fsm
    import mbx_pkg::*;
#(
    parameter int                ADDR_W = 18,
    parameter logic [ADDR_W-1:0] MBOX   = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_pulse,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cs_n,
    input  logic              cs,
    input  logic              wr,
    output logic              irq_n
);
    mb_state_e state, state_nx;
    logic      clr_hit;

    always_comb clr_hit = port_live(cs_n, cs) && !wr && (addr == MBOX);

    always_comb begin
        state_nx = state;
        unique case (state)
            MB_QUIET:  if (set_pulse)              state_nx = MB_RAISED;
            MB_RAISED: if (clr_hit && !set_pulse)  state_nx = MB_QUIET;
            default:                               state_nx = MB_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= MB_QUIET;
        else        state <= state_nx;
    end

    always_comb irq_n = (state != MB_RAISED);

    // R8: an arriving set is never lost to a coinciding clear
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_pulse |=> state == MB_RAISED);

    // R3 (and R5 for the other channel): a clearing read alone drops the flag
    a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && !set_pulse) |=> state == MB_QUIET);

    // R6 / R7: without set or clear the flag keeps its value
    a_r7_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_hit && !set_pulse) |=> $stable(state));

    // R6: with a select inactive no clear can happen
    a_r6_dead_select_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_live(cs_n, cs) && state == MB_RAISED) |=> state == MB_RAISED);

endmodule

// File: rtl/mbx_irq_top.sv
`timescale 1ns/10ps
module mbx_irq_top #(
    parameter int ADDR_W      = 18,
    parameter int SYNC_STAGES = 2
) (
    input  logic              sys_rst_n,
    input  logic              a_clk,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              a_cs_n,
    input  logic              a_cs,
    input  logic              a_wr,
    input  logic              b_clk,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic              b_cs_n,
    input  logic              b_cs,
    input  logic              b_wr,
    output logic              a_irq_n,
    output logic              b_irq_n
);
    localparam int                NPORT    = 2;
    localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

    // Per-port bundles: index 0 is port A, index 1 is port B.
    logic              clk_p   [NPORT];
    logic              rst_p   [NPORT];
    logic [ADDR_W-1:0] addr_p  [NPORT];
    logic [NPORT-1:0]  cs_n_p;
    logic [NPORT-1:0]  cs_p;
    logic [NPORT-1:0]  wr_p;
    logic [NPORT-1:0]  irq_p;

    assign clk_p[0]  = a_clk;
    assign clk_p[1]  = b_clk;
    assign addr_p[0] = a_addr;
    assign addr_p[1] = b_addr;
    assign cs_n_p    = {b_cs_n, a_cs_n};
    assign cs_p      = {b_cs, a_cs};
    assign wr_p      = {b_wr, a_wr};
    assign a_irq_n   = irq_p[0];
    assign b_irq_n   = irq_p[1];

    for (genvar p = 0; p < NPORT; p++) begin : g_rst
        mbx_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
            .clk    (clk_p[p]),
            .arst_n (sys_rst_n),
            .rst_n  (rst_p[p])
        );
    end

    // Channel c: written by port c, read by port 1-c, mailbox TOP_ADDR - c.
    for (genvar c = 0; c < NPORT; c++) begin : g_chan
        localparam int                W    = c;
        localparam int                R    = NPORT - 1 - c;
        localparam logic [ADDR_W-1:0] MBOX = TOP_ADDR - ADDR_W'(c);

        logic tgl;
        logic set_pulse;

        mbx_post_side #(.ADDR_W(ADDR_W), .MBOX(MBOX)) u_post (
            .clk   (clk_p[W]),
            .rst_n (rst_p[W]),
            .addr  (addr_p[W]),
            .cs_n  (cs_n_p[W]),
            .cs    (cs_p[W]),
            .wr    (wr_p[W]),
            .tgl   (tgl)
        );

        mbx_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
            .clk       (clk_p[R]),
            .rst_n     (rst_p[R]),
            .tgl_in    (tgl),
            .set_pulse (set_pulse)
        );

        mbx_flag_fsm #(.ADDR_W(ADDR_W), .MBOX(MBOX)) u_flag (
            .clk       (clk_p[R]),
            .rst_n     (rst_p[R]),
            .set_pulse (set_pulse),
            .addr      (addr_p[R]),
            .cs_n      (cs_n_p[R]),
            .cs        (cs_p[R]),
            .wr        (wr_p[R]),
            .irq_n     (irq_p[R])
        );
    end

endmodule

// File: tb/tb_mbx_irq_top.sv
`timescale 1ns/10ps
module tb_mbx_irq_top;
    localparam int AW = 4;
    localparam logic [AW-1:0] TOPA = '1;

    logic          sys_rst_n = 1'b0;
    logic          a_clk = 1'b0, b_clk = 1'b0;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic          a_cs_n = 1'b1, a_cs = 1'b0, a_wr = 1'b0;
    logic          b_cs_n = 1'b1, b_cs = 1'b0, b_wr = 1'b0;
    logic          a_irq_n, b_irq_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    mbx_irq_top #(.ADDR_W(AW), .SYNC_STAGES(2)) dut (
        .sys_rst_n (sys_rst_n),
        .a_clk (a_clk), .a_addr (a_addr), .a_cs_n (a_cs_n), .a_cs (a_cs), .a_wr (a_wr),
        .b_clk (b_clk), .b_addr (b_addr), .b_cs_n (b_cs_n), .b_cs (b_cs), .b_wr (b_wr),
        .a_irq_n (a_irq_n), .b_irq_n (b_irq_n)
    );

    // 200 MHz on port A; port B at 7 ns, offset so edges never coincide.
    initial forever #2.5 a_clk = ~a_clk;
    initial begin #1.2; forever #3.5 b_clk = ~b_clk; end

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic tick(input int port);
        if (port == 0) @(posedge a_clk); else @(posedge b_clk);
    endtask

    task automatic drive(input int port, input logic [AW-1:0] ad, input logic w,
                         input logic csn, input logic cs);
        if (port == 0) begin a_addr = ad; a_wr = w; a_cs_n = csn; a_cs = cs; end
        else           begin b_addr = ad; b_wr = w; b_cs_n = csn; b_cs = cs; end
    endtask

    task automatic idle(input int port);
        drive(port, '0, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic access(input int port, input logic [AW-1:0] ad, input logic w,
                          input logic csn, input logic cs);
        tick(port); #0.1;
        drive(port, ad, w, csn, cs);
        tick(port); #0.1;
        idle(port);
    endtask

    task automatic do_reset();
        #0.3 sys_rst_n = 1'b0;
        #3   sys_rst_n = 1'b1;
        repeat (5) @(posedge b_clk);
    endtask

    function automatic logic [1:0] irqs();
        return {a_irq_n, b_irq_n};
    endfunction

    initial begin
        #500000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        #2 check("R1 in reset", irqs(), 2'b11);
        #3 sys_rst_n = 1'b1;
        repeat (5) @(posedge b_clk); #0.5;
        check("R1 after release", irqs(), 2'b11);

        // R2: exact edge on which b_irq_n falls
        tick(0); #0.1; drive(0, TOPA, 1'b1, 1'b0, 1'b1);
        @(posedge a_clk); #0.1; idle(0);
        repeat (2) @(posedge b_clk); #0.5;
        check("R2 not before third edge", {1'b1, b_irq_n}, 2'b11);
        @(posedge b_clk); #0.5;
        check("R2 at third edge", {1'b1, b_irq_n}, 2'b10);

        // R4: exact edge on which a_irq_n falls
        tick(1); #0.1; drive(1, TOPA - 1, 1'b1, 1'b0, 1'b1);
        @(posedge b_clk); #0.1; idle(1);
        repeat (2) @(posedge a_clk); #0.5;
        check("R4 not before third edge", {a_irq_n, 1'b1}, 2'b11);
        @(posedge a_clk); #0.5;
        check("R4 at third edge", {a_irq_n, 1'b1}, 2'b01);

        // R3: clear on the sampling edge
        tick(1); #0.1; drive(1, TOPA, 1'b0, 1'b0, 1'b1);
        @(posedge b_clk); #0.5;
        check("R3 clear same edge", irqs(), 2'b01);
        idle(1);

        // R5: clear on the sampling edge
        tick(0); #0.1; drive(0, TOPA - 1, 1'b0, 1'b0, 1'b1);
        @(posedge a_clk); #0.5;
        check("R5 clear same edge", irqs(), 2'b11);
        idle(0);

        // R1: reset while both flags raised forces both high at once
        access(0, TOPA, 1'b1, 1'b0, 1'b1);
        access(1, TOPA - 1, 1'b1, 1'b0, 1'b1);
        repeat (5) @(posedge b_clk); #0.5;
        check("R1 raised before reset", irqs(), 2'b00);
        sys_rst_n = 1'b0; #0.2;
        check("R1 async reset", irqs(), 2'b11);
        #3 sys_rst_n = 1'b1;
        repeat (5) @(posedge b_clk);

        // R6 R7 R2 R3 R4 R5: sweep all accesses from both pre-states
        for (int pre = 0; pre < 2; pre++) begin
            for (int port = 0; port < 2; port++) begin
                for (int ad = 0; ad < (1 << AW); ad++) begin
                    for (int w = 0; w < 2; w++) begin
                        for (int sel = 0; sel < 4; sel++) begin
                            logic csn, cs, live, fa, fb;
                            string tag;
                            csn  = sel[0];
                            cs   = sel[1];
                            live = !csn && cs;
                            do_reset();
                            if (pre == 1) begin
                                access(0, TOPA, 1'b1, 1'b0, 1'b1);
                                access(1, TOPA - 1, 1'b1, 1'b0, 1'b1);
                                repeat (5) @(posedge b_clk);
                            end
                            fa = (pre == 1);
                            fb = (pre == 1);
                            if (live && AW'(ad) == TOPA) begin
                                if (port == 0 && w == 1) fb = 1'b1;
                                if (port == 1 && w == 0) fb = 1'b0;
                            end
                            if (live && AW'(ad) == TOPA - 1) begin
                                if (port == 1 && w == 1) fa = 1'b1;
                                if (port == 0 && w == 0) fa = 1'b0;
                            end
                            access(port, AW'(ad), w[0], csn, cs);
                            repeat (5) @(posedge b_clk); #0.5;
                            tag = $sformatf("R6/R7 sweep pre=%0d port=%0d addr=%0d wr=%0d sel=%0d",
                                            pre, port, ad, w, sel);
                            check(tag, irqs(), {~fa, ~fb});
                        end
                    end
                end
            end
        end

        // R8: clearing read on the k-th reader edge after the write
        for (int dir = 0; dir < 2; dir++) begin
            for (int k = 1; k <= 6; k++) begin
                int wp, rp;
                logic [AW-1:0] mb;
                logic exp_n, got_n;
                wp = dir;
                rp = 1 - dir;
                mb = TOPA - AW'(dir);
                do_reset();
                tick(wp); #0.1; drive(wp, mb, 1'b1, 1'b0, 1'b1);
                tick(wp); #0.1; idle(wp);
                repeat (k - 1) tick(rp);
                if (k > 1) #0.1;
                drive(rp, mb, 1'b0, 1'b0, 1'b1);
                tick(rp); #0.1; idle(rp);
                repeat (6) tick(rp); #0.5;
                exp_n = (k <= 3) ? 1'b0 : 1'b1;
                got_n = (rp == 1) ? b_irq_n : a_irq_n;
                check($sformatf("R8 dir=%0d k=%0d", dir, k), {1'b0, got_n}, {1'b0, exp_n});
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule